// File: doc/BRIEF.md
# Per-Pipe Buffer-Empty Interrupt Controller

This block collects buffer-empty events from the data pipes of a USB host/function controller and merges them into one level-sensitive interrupt. Each pipe has an enable bit and a pending bit. A pending bit is captured only when the pipe's event arrives while that pipe is enabled. The interrupt is high while any pipe has both its pending bit and its enable bit set.

Software reaches the block through a small register port with four word addresses: the enable mask, the pending flags, a one-bit summary and a spare word that reads as zero. A pending flag is acknowledged by writing 0 to its bit. A pipe whose flag is still pending raises the interrupt again as soon as software turns its enable bit back on.

Top module: `bufempty_irq`

## Requirements
- R1: After a synchronous active-low reset, every enable bit and every pending bit is 0, the interrupt is low, and the read data is 0.
- R2: Address 0 holds the enable mask. Bit n enables pipe n for n = 0..9. A write takes effect at the clock edge that samples the write strobe, and a read returns the written value.
- R3: Bits 15..10 of every register read as 0, and writes to them have no effect.
- R4: An event on a pipe whose enable bit is 1 sets that pipe's pending bit, which is read at address 1 in bit n. The interrupt is high from the next cycle on.
- R5: An event on a pipe whose enable bit is 0 leaves its pending bit at 0 and does not raise the interrupt.
- R6: The interrupt equals the OR over all pipes of (pending AND enable). Address 2 returns this value in bit 0.
- R7: Writing 0 to a pending bit at address 1 clears it. Writing 1 leaves it unchanged.
- R8: If a pipe's event and a clear of that pipe's pending bit land in the same cycle, the pending bit ends up set.
- R9: If a pipe's pending bit is 1 and software changes its enable bit from 0 to 1, the interrupt rises in the next cycle.
- R10: The read data is registered. It shows the addressed register in the cycle after the read strobe and holds its value while no read strobe is given. Address 3 reads 0.
- R11: The interrupt drops once no enabled pipe has a pending bit, including when the enable bits of the pending pipes are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_empty | input | 10 | One-cycle buffer-empty event per pipe |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 2 | Register select (0 enable, 1 pending, 2 summary, 3 spare) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The hardest states to reach are a pending bit on a disabled pipe and a clear that meets an event in the same cycle. Pending bits are captured only while their pipe is enabled, so the only way to get a pending bit on a disabled pipe is this sequence: enable the pipe, fire its event, then drop the enable. The bench follows that sequence and then re-enables the pipe to check that the interrupt rises again. For the collision case, a directed task asserts a zero write to the pending register in the same cycle as the pipe's event.

// File: rtl/bempty_pkg.sv
// Shared register selects for the buffer-empty interrupt controller.
// Assumes a two-bit word address on the register port.
package bempty_pkg;
    typedef enum logic [1:0] {
        SEL_ENABLE  = 2'd0,
        SEL_PENDING = 2'd1,
        SEL_SUMMARY = 2'd2,
        SEL_SPARE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/bempty_enable_reg.sv
// Enable mask for the pipes. Only the low NUM_PIPES bits exist,
// so the write data above them is dropped here.
// Assumes the write strobe is already qualified with the address.
module bempty_enable_reg #(
    parameter int NUM_PIPES = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  logic [NUM_PIPES-1:0] wr_bits,
    output logic [NUM_PIPES-1:0] en_q
);
    // Holds the mask and loads it on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (wr_stb) en_q <= wr_bits;
    end
endmodule

// File: rtl/bempty_pending.sv
// Pending flags, one flop per pipe. A flag is set by an event on an
// enabled pipe and cleared by writing 0 to it. When both happen in the
// same cycle, the set wins.
// Assumes events are one-cycle pulses in the clk domain.
module bempty_pending #(
    parameter int NUM_PIPES = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PIPES-1:0] evt,
    input  logic [NUM_PIPES-1:0] en,
    input  logic                 wr_stb,
    input  logic [NUM_PIPES-1:0] wr_bits,
    output logic [NUM_PIPES-1:0] pend_q
);
    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        logic set_p;
        logic clr_p;
        assign set_p = evt[p] & en[p];
        assign clr_p = wr_stb & ~wr_bits[p];
        // One pending flop per pipe; the set takes priority over the clear.
        always_ff @(posedge clk) begin
            if (!rst_n)     pend_q[p] <= 1'b0;
            else if (set_p) pend_q[p] <= 1'b1;
            else if (clr_p) pend_q[p] <= 1'b0;
        end
    end
endmodule

// File: rtl/bempty_readmux.sv
// Registered read path. It loads the selected register on a read
// strobe and holds its value otherwise.
// Assumes NUM_PIPES <= REG_W.
module bempty_readmux
    import bempty_pkg::*;
#(
    parameter int NUM_PIPES = 10,
    parameter int REG_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_stb,
    input  reg_sel_e             sel,
    input  logic [NUM_PIPES-1:0] en,
    input  logic [NUM_PIPES-1:0] pend,
    input  logic                 summary,
    output logic [REG_W-1:0]     rdata
);
    logic [REG_W-1:0] rd_next;

    // Picks the addressed word; bits above NUM_PIPES stay 0.
    always_comb begin
        rd_next = '0;
        unique case (sel)
            SEL_ENABLE:  rd_next[NUM_PIPES-1:0] = en;
            SEL_PENDING: rd_next[NUM_PIPES-1:0] = pend;
            SEL_SUMMARY: rd_next[0]             = summary;
            SEL_SPARE:   rd_next                = '0;
        endcase
    end

    // Captures the read word one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_stb) rdata <= rd_next;
    end
endmodule

// File: rtl/bufempty_irq.sv
// Top of the per-pipe buffer-empty interrupt controller. It decodes the
// register strobes, holds the enable mask and the pending flags, and
// drives the level interrupt from their AND-OR.
// Assumes a single clock and synchronous active-low reset.
module bufempty_irq
    import bempty_pkg::*;
#(
    parameter int NUM_PIPES = 10,
    parameter int REG_W     = 16,
    parameter int ADDR_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PIPES-1:0] pipe_empty,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 irq
);
    reg_sel_e             sel;
    logic                 en_wr;
    logic                 pend_wr;
    logic [NUM_PIPES-1:0] en_q;
    logic [NUM_PIPES-1:0] stat_q;
    logic                 summary;

    assign sel     = reg_sel_e'(reg_addr);
    assign en_wr   = reg_wr & (sel == SEL_ENABLE);
    assign pend_wr = reg_wr & (sel == SEL_PENDING);

    bempty_enable_reg #(.NUM_PIPES(NUM_PIPES)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (en_wr),
        .wr_bits (reg_wdata[NUM_PIPES-1:0]),
        .en_q    (en_q)
    );

    bempty_pending #(.NUM_PIPES(NUM_PIPES)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (pipe_empty),
        .en      (en_q),
        .wr_stb  (pend_wr),
        .wr_bits (reg_wdata[NUM_PIPES-1:0]),
        .pend_q  (stat_q)
    );

    // Summary: any enabled pipe with a pending flag.
    assign summary = |(stat_q & en_q);
    assign irq     = summary;

    bempty_readmux #(.NUM_PIPES(NUM_PIPES), .REG_W(REG_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (reg_rd),
        .sel     (sel),
        .en      (en_q),
        .pend    (stat_q),
        .summary (summary),
        .rdata   (reg_rdata)
    );
endmodule

// File: rtl/bufempty_irq_chk.sv
// Assertion checker bound to bufempty_irq. It watches the ports and the
// enable and pending state.
module bufempty_irq_chk #(
    parameter int NUM_PIPES = 10,
    parameter int REG_W     = 16,
    parameter int ADDR_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PIPES-1:0] pipe_empty,
    input logic                 reg_wr,
    input logic                 reg_rd,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [REG_W-1:0]     reg_wdata,
    input logic [REG_W-1:0]     reg_rdata,
    input logic                 irq,
    input logic [NUM_PIPES-1:0] en_q,
    input logic [NUM_PIPES-1:0] stat_q
);
    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (en_q == '0 && stat_q == '0 && reg_rdata == '0));

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:NUM_PIPES] == '0);

    // R4
    enabled_event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pipe_empty & en_q)) |=> ((stat_q & $past(pipe_empty & en_q)) == $past(pipe_empty & en_q)));

    // R5
    disabled_event_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pipe_empty & ~en_q & ~stat_q)) |=> ((stat_q & $past(pipe_empty & ~en_q & ~stat_q)) == '0));

    // R7
    write_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(1)) |=>
        ((stat_q & $past(stat_q & reg_wdata[NUM_PIPES-1:0])) == $past(stat_q & reg_wdata[NUM_PIPES-1:0])));

    // R9
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((reg_wr && reg_addr == ADDR_W'(0)) || (|pipe_empty)));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

bind bufempty_irq bufempty_irq_chk #(
    .NUM_PIPES(NUM_PIPES), .REG_W(REG_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pipe_empty (pipe_empty),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq        (irq),
    .en_q       (en_q),
    .stat_q     (stat_q)
);

// File: tb/bufempty_irq_bench.sv
module bufempty_irq_bench;
    localparam int NP = 10;
    localparam int NV = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pipe_empty = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bufempty_irq u_bufempty_irq (
        .clk(clk), .rst_n(rst_n), .pipe_empty(pipe_empty),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // Each vector: {kind[1:0], value[15:0], exp_irq, exp_pending[9:0], exp_enable[15:0]}
    // kind 0 = enable write, 1 = pending write, 2 = event
    localparam logic [44:0] VEC [NV] = '{
        {2'd0, 16'hFFFF, 1'b0, 10'h000, 16'h03FF}, // R2 R3
        {2'd2, 16'h0001, 1'b1, 10'h001, 16'h03FF}, // R4
        {2'd1, 16'hFFFF, 1'b1, 10'h001, 16'h03FF}, // R7 write 1 keeps
        {2'd1, 16'hFFFE, 1'b0, 10'h000, 16'h03FF}, // R7 write 0 clears
        {2'd0, 16'h0005, 1'b0, 10'h000, 16'h0005}, // R2
        {2'd2, 16'h0202, 1'b0, 10'h000, 16'h0005}, // R5
        {2'd2, 16'h0204, 1'b1, 10'h004, 16'h0005}, // R4 R5
        {2'd0, 16'h0001, 1'b0, 10'h004, 16'h0001}, // R11
        {2'd0, 16'h0005, 1'b1, 10'h004, 16'h0005}, // R9
        {2'd1, 16'h0000, 1'b0, 10'h000, 16'h0005}, // R11
        {2'd0, 16'h0200, 1'b0, 10'h000, 16'h0200}, // R2
        {2'd2, 16'h0200, 1'b1, 10'h200, 16'h0200}  // R4 R6
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_evt(input logic [NP-1:0] m);
        @(negedge clk);
        pipe_empty = m;
        @(negedge clk);
        pipe_empty = '0;
    endtask

    task automatic do_rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 rdata", 32'(reg_rdata), 0);
        do_rd(2'd0, rv); check("R1 enable", 32'(rv), 0);
        do_rd(2'd1, rv); check("R1 pending", 32'(rv), 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  k;
            logic [15:0] v;
            k = VEC[i][44:43];
            v = VEC[i][42:27];
            case (k)
                2'd0: do_wr(2'd0, v);
                2'd1: do_wr(2'd1, v);
                default: do_evt(v[NP-1:0]);
            endcase
            check($sformatf("R6 irq vec %0d", i), 32'(irq), 32'(VEC[i][26]));
            do_rd(2'd1, rv); check($sformatf("R4 R5 R7 pending vec %0d", i), 32'(rv), 32'(VEC[i][25:16]));
            do_rd(2'd0, rv); check($sformatf("R2 R3 enable vec %0d", i), 32'(rv), 32'(VEC[i][15:0]));
            do_rd(2'd2, rv); check($sformatf("R6 summary vec %0d", i), 32'(rv), 32'(VEC[i][26]));
        end

        // R8: a clear and an event on the same pipe in the same cycle
        do_wr(2'd0, 16'h0008);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0000; pipe_empty = 10'h008;
        @(negedge clk);
        reg_wr = 1'b0; pipe_empty = '0;
        check("R8 irq", 32'(irq), 1);
        do_rd(2'd1, rv); check("R8 pending", 32'(rv), 32'h008);

        // R10: read data holds without a strobe; spare address reads 0
        do_wr(2'd0, 16'h0000);
        check("R11 irq off", 32'(irq), 0);
        repeat (2) @(negedge clk);
        check("R10 hold", 32'(reg_rdata), 32'h008);
        do_rd(2'd3, rv); check("R10 spare", 32'(rv), 0);

        // R3: writes to reserved bits have no effect
        do_wr(2'd0, 16'hFC00);
        do_rd(2'd0, rv); check("R3 reserved", 32'(rv), 0);

        // R1: reset in the middle of operation
        do_wr(2'd0, 16'h0008);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 irq after reset", 32'(irq), 0);
        do_rd(2'd1, rv); check("R1 pending after reset", 32'(rv), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule